// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small processor core. A call or an interrupt entry pushes a 13-bit address, normally the address of the instruction after the call, and a return pops it. The most recent address is always shown on the top-of-stack output, so the program-counter logic can load it directly when a return executes.

The stack has eight levels and is built as a ring. A 3-bit pointer moves up by one on a push and down by one on a pop, modulo eight. The stack never reports that it is full or empty. A ninth push without a matching pop overwrites the oldest entry. Extra pops keep walking backwards through the ring and return whatever older contents are stored there.

A push and a pop in the same cycle replace the top entry in place and leave the depth unchanged. The control path decodes each cycle into one of four named operations: HOLD (no request), PUSH, POP and SWAP (push and pop together). A single pointer register is the only state that these operations move between values. Any program-counter high-byte latch sits outside this block, and stack operations do not touch it.

Top module: `ret_stack`

## Requirements
- R1: An active-low reset sets the pointer to zero and leaves the stored entries unchanged, so the first push after reset writes entry 0, and a pop from there shows entry 7.
- R2: With `push_i`=1 and `pop_i`=0 (PUSH), `push_addr_i` is written at the pointer and the pointer advances by one. From the next cycle on, `tos_o` shows the pushed value.
- R3: The pointer wraps modulo 8 with no overflow indication. The ninth push overwrites the entry written by the first push, the tenth overwrites the second, and so on.
- R4: With `pop_i`=1 and `push_i`=0 (POP), the pointer steps back by one, modulo 8, and from the next cycle `tos_o` shows the entry below. Pops past the bottom keep cycling through older ring contents.
- R5: With `push_i`=1 and `pop_i`=1 (SWAP), the entry at pointer minus one is replaced by `push_addr_i` and the pointer is unchanged. `tos_o` shows the new value from the next cycle, and a following pop shows the entry that lay below it.
- R6: With neither request (HOLD), the pointer, the entries and `tos_o` keep their values.
- R7: Every one of the 13 address bits is stored and returned exactly, including the all-zero, all-one and alternating patterns.
- R8: Eight pushes followed by eight pops return the eight addresses in reverse order of pushing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pointer |
| push_i | input | 1 | Push request (call or interrupt entry) |
| pop_i | input | 1 | Pop request (return) |
| push_addr_i | input | 13 | Return address to store on a push or swap |
| tos_o | output | 13 | Entry at pointer minus one |

## Verification
The assertions check four things on every cycle: a PUSH or SWAP shows the written address on the next cycle, the pointer steps by +1, -1 or 0 according to the decoded operation, HOLD keeps both the pointer and the output stable, and the pointer is zero when reset is released. Some behaviours appear only over a sequence of operations, so only the bench's scenarios can show them. These are the wrap that overwrites the oldest entry, the last-in-first-out order across all eight levels, underflow reading back older ring contents, and entries surviving a reset. The bench reaches them by comparing against a behavioural ring model on every clock.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Operation decoded from {push, pop} each cycle
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_SWAP = 2'b11
    } rstk_op_e;

endpackage

// File: rtl/rstk_ctl.sv
module rstk_ctl
    import rstk_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [PTR_W-1:0] ptr_q,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx
);

    rstk_op_e         op;
    logic [PTR_W-1:0] ptr_d;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;

    assign op     = rstk_op_e'({push_i, pop_i});
    assign ptr_up = ptr_q + PTR_W'(1);
    assign ptr_dn = ptr_q - PTR_W'(1);

    // Pointer register: the only state the operations move
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // Next pointer per operation (ring wraps naturally)
    always_comb begin
        unique case (op)
            OP_HOLD: ptr_d = ptr_q;
            OP_PUSH: ptr_d = ptr_up;
            OP_POP:  ptr_d = ptr_dn;
            OP_SWAP: ptr_d = ptr_q;
            default: ptr_d = ptr_q;
        endcase
    end

    // Storage controls per operation
    always_comb begin
        rd_idx = ptr_dn;
        unique case (op)
            OP_PUSH: begin wr_en = 1'b1; wr_idx = ptr_q;  end
            OP_SWAP: begin wr_en = 1'b1; wr_idx = ptr_dn; end
            OP_HOLD: begin wr_en = 1'b0; wr_idx = ptr_q;  end
            OP_POP:  begin wr_en = 1'b0; wr_idx = ptr_q;  end
            default: begin wr_en = 1'b0; wr_idx = ptr_q;  end
        endcase
    end

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int WIDTH = 13,
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [DEPTH-1:0][WIDTH-1:0] rows;

    // One register per level; entries are not reset
    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        logic [WIDTH-1:0] q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == AW'(g))) q <= wr_data;
        end
        assign rows[g] = q;
    end

    assign rd_data = rows[rd_idx];

endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int ADDR_W = 13,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    output logic [ADDR_W-1:0] tos_o
);

    // DEPTH must be a power of two for the modulo wrap
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0] ptr_q;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;

    rstk_ctl #(.PTR_W(PTR_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push_i),
        .pop_i  (pop_i),
        .ptr_q  (ptr_q),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx)
    );

    rstk_store #(.WIDTH(ADDR_W), .DEPTH(DEPTH), .AW(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_addr_i),
        .rd_idx  (rd_idx),
        .rd_data (tos_o)
    );

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
    parameter int W  = 13,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic [W-1:0]  push_addr_i,
    input logic [W-1:0]  tos_o,
    input logic [PW-1:0] ptr
);

    // R1: pointer is zero on the first cycle out of reset
    a_r1_reset_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ptr == '0);

    // R2: pushed address appears on top next cycle
    a_r2_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> tos_o == $past(push_addr_i));

    // R3: push advances pointer modulo depth
    a_r3_push_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> ptr == PW'($past(ptr) + PW'(1)));

    // R4: pop steps pointer back modulo depth
    a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> ptr == PW'($past(ptr) - PW'(1)));

    // R5: push with pop replaces top and keeps pointer
    a_r5_swap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (tos_o == $past(push_addr_i)) && $stable(ptr));

    // R6: idle holds pointer and output
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(ptr) && $stable(tos_o));

endmodule

bind ret_stack ret_stack_chk #(.W(ADDR_W), .PW(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .tos_o       (tos_o),
    .ptr         (ptr_q)
);

// File: tb/ret_stack_tb.sv
`timescale 1ns/1ps
module ret_stack_tb;

    localparam int W = 13;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 1'b0;
    logic         pop_i = 1'b0;
    logic [W-1:0] push_addr_i = '0;
    logic [W-1:0] tos_o;

    int m_mem [D];
    bit m_vld [D];
    int m_ptr = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ret_stack #(.ADDR_W(W), .DEPTH(D)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .push_addr_i (push_addr_i),
        .tos_o       (tos_o)
    );

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check_tos(string tag);
        int top;
        top = (m_ptr + D - 1) % D;
        if (m_vld[top]) begin
            n_cmp++;
            if (tos_o !== W'(m_mem[top])) begin
                n_bad++;
                $display("FAIL %s: tos=%h expected=%h", tag, tos_o, W'(m_mem[top]));
            end
        end
    endtask

    // Drive at a falling edge, let one rising edge act, compare at the next falling edge
    task automatic step(bit pu, bit po, logic [W-1:0] d, string tag);
        push_i = pu;
        pop_i = po;
        push_addr_i = d;
        @(negedge clk);
        if (pu && !po) begin
            m_mem[m_ptr] = int'(d);
            m_vld[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % D;
        end else if (po && !pu) begin
            m_ptr = (m_ptr + D - 1) % D;
        end else if (pu && po) begin
            m_mem[(m_ptr + D - 1) % D] = int'(d);
            m_vld[(m_ptr + D - 1) % D] = 1'b1;
        end
        check_tos(tag);
    endtask

    task automatic do_reset();
        push_i = 1'b0;
        pop_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        m_ptr = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: first push after reset lands in entry 0
        step(1, 0, 13'h0001, "R1 first push after reset");
        // R7: full-width patterns
        step(1, 0, 13'h1FFF, "R7 all ones");
        step(1, 0, 13'h0AAA, "R7 alternating A");
        step(1, 0, 13'h1555, "R7 alternating 5");
        step(1, 0, 13'h0000, "R7 all zero");
        // R4: pops reveal lower entries
        step(0, 1, '0, "R4 pop one");
        step(0, 1, '0, "R4 pop two");
        // R6: idle holds
        for (int i = 0; i < 3; i++) step(0, 0, 13'h1234, "R6 idle hold");
        // R5: replace top, then the entry below is intact
        step(1, 1, 13'h0123, "R5 swap top");
        step(0, 0, '0, "R5 after swap idle");
        step(0, 1, '0, "R5 pop after swap");
        step(0, 1, '0, "R5 second pop after swap");

        // R8: eight pushes then eight pops in reverse order
        for (int i = 0; i < D; i++) step(1, 0, W'(13'h0100 + i * 13'h0011), "R8 fill");
        for (int i = 0; i < D; i++) step(0, 1, '0, "R8 drain reverse order");

        // R3: ninth and tenth pushes overwrite the oldest entries
        for (int i = 0; i < D + 2; i++) step(1, 0, W'(13'h0800 + i * 13'h0101), "R3 wrap push");
        for (int i = 0; i < D + 3; i++) step(0, 1, '0, "R3 R4 pop through ring");

        // R1: mid-run reset keeps contents, pointer back to zero
        step(1, 0, 13'h0F0F, "R1 pre-reset push");
        step(1, 0, 13'h10F0, "R1 pre-reset push");
        do_reset();
        step(1, 0, 13'h0777, "R1 push after mid reset");
        step(0, 1, '0, "R1 pop to entry 7 after reset");
        step(0, 1, '0, "R1 pop to entry 6 after reset");

        // Mixed traffic covering R2 R4 R5 R6
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 3);
            step(r[1], r[0], W'($urandom), "R2 R4 R5 R6 mixed");
        end

        done = 1'b1;
        finish_up();
    end

endmodule